// File: doc/BRIEF.md
# Wall-Switch Power Level Sequencer

This block picks the drive level for a constant-current lamp driver from the way a user works the wall switch. It watches a supply-present flag, which may be asynchronous and bouncy, and times every interval during which the supply is absent. When power returns after a short absence, the block moves one step along a cyclic sequence of levels. When power returns after a long absence, it restarts at full level. The output is a percentage byte that a current reference can use directly.

Two strap inputs choose one of four sequences. Each strap reads 1 when it is left floating and 0 when it is tied to ground. The straps are captured once, at each power-on edge. The logic that holds the sequence state must stay clocked and powered while the supply flag is low. The short/long threshold is a parameter in clock cycles. It is typically set to about four seconds of the clock.

Top module: `mains_level_seq`

## Requirements
- R1: After reset, with the supply flag low, `supply_valid` is 0 and `level_pct` is 0.
- R2: The first power-on after reset reports `level_pct` = 100.
- R3: A power-on that follows an absence shorter than `OFF_LIMIT` cycles advances the step index by one. Past the last step of the sequence, the index wraps to step 0 (100).
- R4: A power-on that follows an absence of at least `OFF_LIMIT` cycles reports 100 and restarts the sequence. The absence timer saturates, so any longer absence behaves the same way.
- R5: With straps {cfg_a,cfg_b} = 2'b11 (both floating), the level is always 100.
- R6: With straps 2'b10 (cfg_a floating, cfg_b grounded), the sequence is 100, 30, 100, 30, …
- R7: With straps 2'b01 (cfg_a grounded, cfg_b floating), the sequence is 100, 50, 100, 50, …
- R8: With straps 2'b00 (both grounded), the sequence is 100, 50, 20, 100, …
- R9: The straps are captured only at a power-on edge. Changing them while power is present does not change `level_pct`.
- R10: A dropout of the supply flag that lasts fewer than `DEB_CYCLES` cycles is ignored. It causes no power-on edge and no change in level.
- R11: While `supply_valid` is 1, `level_pct` holds constant and is one of 100, 50, 30 or 20. While `supply_valid` is 0, `level_pct` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| supply_ok | input | 1 | Raw supply-present flag, asynchronous |
| cfg_a | input | 1 | First sequence strap, 1 = floating, 0 = grounded |
| cfg_b | input | 1 | Second sequence strap, 1 = floating, 0 = grounded |
| supply_valid | output | 1 | Synchronised, debounced supply-present state |
| level_pct | output | 8 | Selected drive level in percent, 0 while off |

## Verification
The hardest situations to reach from the ports are the index wrap in the three-step sequence and a strap change between two short cycles. The stimulus drives long chains of short off intervals, three or more in a row, so that the wrap from 20 back to 100 is observed. It also alters the straps during an on period and again just before a power-on. Supply glitches shorter than the debounce window are injected while the lamp is on. The scoreboard then confirms that no extra power-on edge appears and that the level does not move.

// File: rtl/mains_level_seq.sv
module mains_level_seq #(
  parameter int unsigned OFF_LIMIT  = 1_000_000_000,
  parameter int unsigned DEB_CYCLES = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_ok,
  input  logic       cfg_a,
  input  logic       cfg_b,
  output logic       supply_valid,
  output logic [7:0] level_pct
);
  localparam int unsigned OFF_W = $clog2(OFF_LIMIT + 1);
  localparam int unsigned DEB_W = $clog2(DEB_CYCLES + 1);

  logic [1:0]       sync_q;
  logic             raw;
  logic             on_q;
  logic [DEB_W-1:0] deb_cnt;
  logic [OFF_W-1:0] off_cnt;
  logic [1:0]       cfg_q;
  logic [1:0]       step_q;
  logic             rise;
  logic             long_off;
  logic [1:0]       seq_len;
  logic [1:0]       step_nx;
  logic [7:0]       pct;

  assign raw      = sync_q[1];
  assign rise     = raw && !on_q && (deb_cnt == DEB_W'(DEB_CYCLES - 1));
  assign long_off = (off_cnt == OFF_W'(OFF_LIMIT));

  always_comb begin
    case ({cfg_a, cfg_b})
      2'b11:   seq_len = 2'd1;
      2'b00:   seq_len = 2'd3;
      default: seq_len = 2'd2;
    endcase
    step_nx = ((step_q + 2'd1) >= seq_len) ? 2'd0 : step_q + 2'd1;
  end

  always_comb begin
    case (step_q)
      2'd1:    pct = (cfg_q == 2'b10) ? 8'd30 : 8'd50;
      2'd2:    pct = 8'd20;
      default: pct = 8'd100;
    endcase
  end

  assign supply_valid = on_q;
  assign level_pct    = on_q ? pct : 8'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], supply_ok};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q    <= 1'b0;
      deb_cnt <= '0;
    end else if (raw == on_q) begin
      deb_cnt <= '0;
    end else if (deb_cnt == DEB_W'(DEB_CYCLES - 1)) begin
      on_q    <= raw;
      deb_cnt <= '0;
    end else begin
      deb_cnt <= deb_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         off_cnt <= OFF_W'(OFF_LIMIT);
    else if (on_q)      off_cnt <= '0;
    else if (!long_off) off_cnt <= off_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= 2'b11;
      step_q <= 2'd0;
    end else if (rise) begin
      cfg_q  <= {cfg_a, cfg_b};
      step_q <= long_off ? 2'd0 : step_nx;
    end
  end

  p_off_sat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    off_cnt <= OFF_W'(OFF_LIMIT));

  p_long_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(on_q) && ($past(off_cnt) == OFF_W'(OFF_LIMIT)) |-> level_pct == 8'd100);

  p_float_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    on_q && (cfg_q == 2'b11) |-> level_pct == 8'd100);

  p_hold_on_r11: assert property (@(posedge clk) disable iff (!rst_n)
    on_q && $past(on_q) |-> $stable(level_pct));

  p_legal_level_r11: assert property (@(posedge clk) disable iff (!rst_n)
    on_q |-> (level_pct == 8'd100 || level_pct == 8'd50 ||
              level_pct == 8'd30  || level_pct == 8'd20));

  p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    on_q && $past(on_q) |-> $stable(cfg_q));
endmodule

// File: tb/mains_level_seq_tb.sv
module mains_level_seq_tb_top;
  localparam int unsigned OFF_LIM = 200;
  localparam int unsigned DEB     = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       supply_ok = 1'b0;
  logic       cfg_a = 1'b1;
  logic       cfg_b = 1'b1;
  logic       supply_valid;
  logic [7:0] level_pct;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  mains_level_seq #(.OFF_LIMIT(OFF_LIM), .DEB_CYCLES(DEB)) dut_i (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .cfg_a(cfg_a), .cfg_b(cfg_b),
    .supply_valid(supply_valid), .level_pct(level_pct)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic power_on(input bit a, input bit b, input int exp, input string req);
    cfg_a = a;
    cfg_b = b;
    exp_q.push_back(exp);
    tag_q.push_back(req);
    supply_ok = 1'b1;
    wait_cyc(30);
  endtask

  task automatic power_off(input int cycles);
    supply_ok = 1'b0;
    wait_cyc(20);
    check(supply_valid == 1'b0 && level_pct == 8'd0, "R11 off level", level_pct, 0);
    wait_cyc(cycles - 20);
  endtask

  always @(posedge supply_valid) begin
    wait_cyc(2);
    if (exp_q.size() == 0) begin
      check(1'b0, "R10 unexpected power-on", level_pct, -1);
    end else begin
      int e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(level_pct == 8'(e), t, level_pct, e);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    wait_cyc(5);
    check(supply_valid == 1'b0 && level_pct == 8'd0, "R1 reset", level_pct, 0);
    rst_n = 1'b1;
    wait_cyc(5);
    check(supply_valid == 1'b0 && level_pct == 8'd0, "R1 after reset", level_pct, 0);

    power_on(1'b0, 1'b0, 100, "R2 first power-on");
    power_off(100); power_on(1'b0, 1'b0, 50,  "R8 step 50");
    power_off(100); power_on(1'b0, 1'b0, 20,  "R8 step 20");
    power_off(100); power_on(1'b0, 1'b0, 100, "R3 wrap to 100");
    power_off(100); power_on(1'b0, 1'b0, 50,  "R3 advance again");
    power_off(400); power_on(1'b1, 1'b0, 100, "R4 long restart");
    power_off(100); power_on(1'b1, 1'b0, 30,  "R6 step 30");
    power_off(100); power_on(1'b1, 1'b0, 100, "R6 wrap 100");
    power_off(100); power_on(1'b1, 1'b0, 30,  "R6 cyclic 30");
    power_off(2000); power_on(1'b0, 1'b1, 100, "R4 saturated long restart");
    power_off(100); power_on(1'b0, 1'b1, 50,  "R7 step 50");
    power_off(100); power_on(1'b0, 1'b1, 100, "R7 wrap 100");

    cfg_a = 1'b1; cfg_b = 1'b0;
    wait_cyc(10);
    check(level_pct == 8'd100, "R9 strap change while on", level_pct, 100);

    supply_ok = 1'b0;
    wait_cyc(2);
    supply_ok = 1'b1;
    wait_cyc(20);
    check(supply_valid == 1'b1 && level_pct == 8'd100, "R10 glitch ignored", level_pct, 100);

    power_off(100); power_on(1'b0, 1'b0, 50,  "R9 straps taken at power-on");
    power_off(100); power_on(1'b1, 1'b1, 100, "R5 floating straps");
    power_off(100); power_on(1'b1, 1'b1, 100, "R5 no sequencing");
    power_off(100);

    check(exp_q.size() == 0, "R3 pending items", exp_q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule